// File: doc/BRIEF.md
# Sine PWM Generator

This block drives one PWM output whose duty cycle follows a sine wave. Duty values come from a 256-entry table that holds exactly one output cycle. The table is built at elaboration time, so it needs no memory file. A free-running 8-bit carrier counter sets the PWM period. A separate step divider runs at 256 times the output frequency. On each of its ticks it advances a table address.

The two rates are independent of each other. On a step tick the live address is first saved into a holding register and then incremented. The carrier reads the table through that holding register, and it reloads its duty compare only at the boundary between two carrier periods. A duty value therefore never changes part way through a period.

The output frequency is chosen once, from the mode input, in the first clock after reset is released. The two step dividers are parameters. The defaults are scaled so that the carrier period is shorter than one step, which is the condition for showing every table point.

Top module: `spwm_gen`

## Requirements
- R1: While rst_ni is low, pwm_o and zero_o are low, and the table address, holding register and duty compare are all 0. The duty compare is therefore 0 in the first carrier period after reset.
- R2: Table entry p (0..255) is built as follows. Let q = p mod 128, ab = q*(128-q) and s = (508*ab) div (20480-ab). The entry is then 128+s for p<128 and 128-s for p>=128. This gives a peak of 255 at p=64, 1 at p=192, and 128 at p=0 and p=128.
- R3: The carrier counter runs from 0 to 255 and advances once every CAR_PRESC clocks, so one period lasts 256*CAR_PRESC clocks. period_start_o is high for the first clock of each period, including the clock that follows reset release.
- R4: pwm_o is high exactly while the carrier counter is below the active duty compare. In each period it is therefore high for compare*CAR_PRESC clocks: a compare of 0 keeps it low, and 255 gives 255/256 duty.
- R5: The first clock edge after reset release arms the step divider. Tick n (n>=1) then takes effect on the edge numbered n*DIV+1 after release, where DIV is the divider for the latched mode. Two ticks are never adjacent.
- R6: On each tick the holding register takes the current address, and the address increments by one, wrapping from 255 to 0.
- R7: The duty compare changes only on the edge that ends a carrier period. It then takes the table entry selected by the value the holding register had in the last clock of that period.
- R8: mode_sel_i = 1 selects STEP_DIV_60 and mode_sel_i = 0 selects STEP_DIV_50. The value is sampled on the first edge after reset release, and later changes have no effect until the next reset.
- R9: zero_o is a one-clock pulse in the clock that follows a tick which copies address 0 into the holding register.
- R10: With step dividers larger than the carrier period, at most one tick falls between two duty reloads. Consecutive periods therefore use the same table index or the next one, and no index is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 1 | Frequency mode (1: 60 Hz divider, 0: 50 Hz divider), sampled once after reset |
| pwm_o | output | 1 | Sine-modulated PWM output |
| period_start_o | output | 1 | High in the first clock of each carrier period |
| zero_o | output | 1 | Pulse when address 0 enters the holding register |

## Verification
The scoreboard measures the high time of every carrier period and compares it with the entry chosen by the holding register at the end of the previous period. A design that read the live address instead would run one index ahead, and one that reloaded mid-period would give lengths that match no entry. The 60 Hz run runs past 256 steps. It therefore catches an address that fails to wrap, or a zero pulse that appears in the wrong place or appears twice. Both runs toggle the mode input after start-up, which exposes a divider that keeps following the live input. The first period after reset must be fully low, so a compare that is not cleared by reset is caught.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned TAB_AW  = 8;
  localparam int unsigned TAB_DW  = 8;
  localparam int unsigned TAB_LEN = 1 << TAB_AW;
  localparam int unsigned HALF    = TAB_LEN / 2;

  // rational sine approximation over each half cycle, centred on 128
  function automatic logic [TAB_DW-1:0] sine_entry(input int unsigned p);
    int unsigned q, ab, s;
    q  = p % HALF;
    ab = q * (HALF - q);
    s  = (508 * ab) / (20480 - ab);
    return (p < HALF) ? TAB_DW'(128 + s) : TAB_DW'(128 - s);
  endfunction
endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom
  import spwm_pkg::*;
(
  input  logic [TAB_AW-1:0] addr_i,
  output logic [TAB_DW-1:0] data_o
);
  logic [TAB_DW-1:0] tab [TAB_LEN];

  for (genvar i = 0; i < TAB_LEN; i++) begin : g_tab
    assign tab[i] = sine_entry(i);
  end

  assign data_o = tab[addr_i];
endmodule

// File: rtl/spwm_step.sv
module spwm_step #(
  parameter int unsigned DIV_50 = 400,
  parameter int unsigned DIV_60 = 333,
  parameter int unsigned AW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  output logic          tick_o,
  output logic [AW-1:0] hold_o,
  output logic          zero_o
);
  localparam int unsigned DMAX = (DIV_50 > DIV_60) ? DIV_50 : DIV_60;
  localparam int unsigned SW   = $clog2(DMAX);

  logic          armed_q, mode_q, zero_q;
  logic [SW-1:0] cnt_q, lim;
  logic [AW-1:0] addr_q, hold_q;

  assign lim    = mode_q ? SW'(DIV_60 - 1) : SW'(DIV_50 - 1);
  assign tick_o = armed_q && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      hold_q  <= '0;
      zero_q  <= 1'b0;
    end else begin
      zero_q <= 1'b0;
      if (!armed_q) begin
        armed_q <= 1'b1;
        mode_q  <= mode_i;
      end else if (tick_o) begin
        cnt_q  <= '0;
        hold_q <= addr_q;
        addr_q <= addr_q + AW'(1);
        zero_q <= (addr_q == '0);
      end else begin
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end

  assign hold_o = hold_q;
  assign zero_o = zero_q;

  // R6
  addr_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != addr_q) |-> (addr_q == hold_q + AW'(1)));
  // R8
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(mode_q));
  // R9
  zero_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_q |-> (hold_q == '0 && addr_q == AW'(1)));
  // R5
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int unsigned CAR_PRESC = 1,
  parameter int unsigned DW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] duty_i,
  output logic          load_o,
  output logic          period_start_o,
  output logic          pwm_o
);
  localparam int unsigned PW      = (CAR_PRESC > 1) ? $clog2(CAR_PRESC) : 1;
  localparam int unsigned CNT_MAX = (1 << DW) - 1;

  logic [PW-1:0] presc_q;
  logic [DW-1:0] cnt_q, cmp_q;
  logic          adv, wrap;

  assign adv  = (presc_q == PW'(CAR_PRESC - 1));
  assign wrap = adv && (cnt_q == DW'(CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
    end else begin
      presc_q <= adv ? '0 : presc_q + PW'(1);
      if (adv)  cnt_q <= cnt_q + DW'(1);
      if (wrap) cmp_q <= duty_i;
    end
  end

  assign load_o         = wrap;
  assign period_start_o = (cnt_q == '0) && (presc_q == '0);
  assign pwm_o          = (cnt_q < cmp_q);

  // R7
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(cmp_q));
  // R3
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> period_start_o);
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
#(
  parameter int unsigned CAR_PRESC   = 1,
  parameter int unsigned STEP_DIV_50 = 400,
  parameter int unsigned STEP_DIV_60 = 333
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_sel_i,
  output logic pwm_o,
  output logic period_start_o,
  output logic zero_o
);
  logic              tick, load;
  logic [TAB_AW-1:0] hold;
  logic [TAB_DW-1:0] duty;

  spwm_step #(
    .DIV_50(STEP_DIV_50),
    .DIV_60(STEP_DIV_60),
    .AW    (TAB_AW)
  ) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_sel_i),
    .tick_o(tick),
    .hold_o(hold),
    .zero_o(zero_o)
  );

  spwm_sine_rom u_rom (
    .addr_i(hold),
    .data_o(duty)
  );

  spwm_carrier #(
    .CAR_PRESC(CAR_PRESC),
    .DW       (TAB_DW)
  ) u_car (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .duty_i        (duty),
    .load_o        (load),
    .period_start_o(period_start_o),
    .pwm_o         (pwm_o)
  );

  // steps seen since the last duty reload
  logic [1:0] steps_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      steps_q <= '0;
    else if (load)                    steps_q <= {1'b0, tick};
    else if (tick && steps_q != 2'd3) steps_q <= steps_q + 2'd1;
  end

  // R10
  no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= 2'd1);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pwm_o && !zero_o));
endmodule

// File: tb/spwm_gen_test.sv
module spwm_gen_test;
  localparam int P   = 1;
  localparam int D50 = 360;
  localparam int D60 = 300;
  localparam int PER = 256 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic pwm, pstart, zero;

  spwm_gen #(.CAR_PRESC(P), .STEP_DIV_50(D50), .STEP_DIV_60(D60)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_sel_i(mode_sel),
    .pwm_o(pwm), .period_start_o(pstart), .zero_o(zero)
  );

  always #2.5 clk = ~clk;

  typedef struct { int edge_n; int duty; } item_t;
  item_t exp_q[$];
  item_t cur;

  int n_chk = 0, n_err = 0;
  int e = 0, cur_div = D60, hi = 0, zc = 0, end_edge = 0;
  bit open = 0, mon_on = 0, done = 0;

  always @(posedge clk) e <= rst_n ? e + 1 : 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R2 table formula
  function automatic int entry(input int p);
    int q, ab, s;
    q  = p % 128;
    ab = q * (128 - q);
    s  = (508 * ab) / (20480 - ab);
    return (p < 128) ? 128 + s : 128 - s;
  endfunction

  // R5 R6: holding register value after edge n
  function automatic int hold_after(input int n, input int div);
    int t;
    t = (n >= 1) ? (n - 1) / div : 0;
    return (t >= 1) ? (t - 1) % 256 : 0;
  endfunction

  // monitor: R3 period timing, R4/R7/R10 duty per period, R9 zero pulses
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (pstart) begin
        if (open) chk(hi == cur.duty, "R4 R7 R10 period duty", hi, cur.duty);
        if (exp_q.size() > 0) begin
          cur  = exp_q.pop_front();
          open = 1;
          chk(e == cur.edge_n, "R3 period start edge", e, cur.edge_n);
          hi = 0;
        end else open = 0;
      end
      if (open && pwm) hi++;
      if (zero && e < end_edge) begin
        zc++;
        chk(((e - 1) % cur_div == 0) && (((e - 1) / cur_div) % 256 == 1),
            "R9 zero pulse edge", e, ((e - 1) / cur_div) * cur_div + 1);
      end
    end
  end

  task automatic run(input bit mode, input int div, input int nper, input int flip_at);
    int zexp;
    rst_n = 0;
    mode_sel = mode;
    cur_div = div;
    repeat (3) @(negedge clk);
    chk(pwm == 0, "R1 pwm in reset", pwm, 0);
    chk(zero == 0, "R1 zero in reset", zero, 0);
    // driver: expected duty for every period
    for (int m = 0; m < nper; m++) begin
      item_t it;
      it.edge_n = PER * m;
      it.duty   = (m == 0) ? 0 : entry(hold_after(PER * m - 1, div)) * P;
      exp_q.push_back(it);
    end
    end_edge = PER * (nper - 1);
    zc = 0;
    open = 0;
    mon_on = 1;
    @(posedge clk);
    #1 rst_n = 1;
    while (exp_q.size() != 0 || open) begin
      @(negedge clk);
      if (e == flip_at) mode_sel = ~mode_sel; // R8: ignored after start-up
    end
    mon_on = 0;
    zexp = 0;
    for (int n = 1; n * div + 1 < end_edge; n++)
      if (n % 256 == 1) zexp++;
    chk(zc == zexp, "R9 R6 zero pulse count", zc, zexp);
    rst_n = 0;
  endtask

  initial begin
    run(1'b1, D60, 305, 30000); // R8 mode 1, wraps past address 255
    run(1'b0, D50, 60, 5000);   // R8 mode 0
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule